// File: doc/BRIEF.md
# Timekeeping Health Flags

This block holds two sticky status flags for a real-time-clock style device. The halt flag reports that the 32.768 kHz timekeeping clock stopped. The drop flag reports that the supply fell below the trip level of an external comparator. The block samples the slow clock as an ordinary signal, using a free-running reference clock. It watches the slow clock for rising edges and declares a halt when none arrives within a programmable number of reference cycles. Halt sensing only runs while the chip-enable pin is low. The comparator output must stay asserted for a programmable number of cycles before it counts, so that chatter is filtered out.

Software sees four byte-wide registers through a single-cycle write port and a combinational read port. Neither flag can be set from software. Software can only clear a flag, by writing 0 to it. A detected halt also wipes the adjustment, control, scratch and interrupt-flag bits. The status output encodes both flags, and the halt flag takes precedence. After power-on reset, neither flag can become set until a programmable number of slow-clock edges has been seen.

Top module: `rtc_health_flags`

## Requirements
- R1: After reset, halt_flag is 1, drop_flag is 0, init_done is 0, every register bit other than the halt flag reads 0, and status is 2'b10.
- R2: After init_done, if ce is low and the synchronised slow clock shows no rising edge for more than HALT_TIMEOUT reference cycles, halt_flag becomes 1.
- R3: While ce is high, no halt is detected and halt_flag cannot become set. A halt flag that is already set stays set when ce goes high.
- R4: After init_done, drop_flag becomes 1 once the synchronised comparator input has been high for DROP_HOLD consecutive cycles. Shorter pulses leave the flag unchanged.
- R5: Writing register 2 with bit 7 = 0 clears halt_flag, and with bit 6 = 0 clears drop_flag. Writing 1 to either bit has no effect.
- R6: If a clearing write and a set condition for the same flag occur in the same cycle, the flag stays 1.
- R7: In every cycle a halt is detected, all the following become 0 and any write in that cycle is lost: register 0, register 1, register 2 bits 6..4 (including drop_flag), and register 3.
- R8: status is 2'b10 while halt_flag is 1. It is 2'b01 when only drop_flag is 1, and 2'b00 when both flags are 0.
- R9: thr_sel equals register 2 bit 5. It selects the comparator trip level: 1 = higher level, 0 = lower level.
- R10: Before INIT_EDGES rising edges of the slow clock have been seen since reset, neither flag can become set, and init_done is 0.
- R11: Register layout:
  - Register 0: bits 6..0 hold the trim value; bit 7 reads 0.
  - Register 1: bits 7..5 hold the periodic select, bit 4 the test bit, bit 3 clock-out enable 1, bit 2 the hour-mode select, and bits 1..0 the alarm enables.
  - Register 2: bit 7 is the halt flag, bit 6 the drop flag, bit 5 thr_sel and bit 4 clock-out enable 2; bits 3..0 read 0.
  - Register 3: bits 5..3 are scratch and bits 2..0 are interrupt flags; bits 7..6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_in | input | 1 | Sampled 32.768 kHz timekeeping clock |
| cmp_low | input | 1 | Comparator output, high when the supply is below the threshold |
| ce | input | 1 | Chip-enable pin; halt sensing runs only while it is low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| thr_sel | output | 1 | Threshold select driven to the comparator |
| halt_flag | output | 1 | Oscillation-halt flag |
| drop_flag | output | 1 | Supply-drop flag |
| status | output | 2 | Encoded health status |
| init_done | output | 1 | Initialisation period finished |

## Verification
The bench stops the slow clock with ce high and checks that no halt is flagged. A design that ignored ce would set the flag here. It then stops the slow clock with ce low and checks that the halt wipes the configured registers. A design that only set the flag would leave stale configuration behind. The bench also issues clearing writes while the halt or drop condition is still present, and writes 1s to both flag bits. A wrong priority shows up as a flag that clears while the condition persists, or as a flag that software can set. Finally, the bench resets with the slow clock stopped and the comparator high, to check that nothing is flagged before the initialisation edges arrive.

// File: rtl/rtc_flags_pkg.sv
package rtc_flags_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'b00,
        ST_SUPPLY  = 2'b01,
        ST_HALTED  = 2'b10
    } health_e;

    localparam logic [1:0] A_TRIM = 2'd0;
    localparam logic [1:0] A_CTLA = 2'd1;
    localparam logic [1:0] A_CTLB = 2'd2;
    localparam logic [1:0] A_AUX  = 2'd3;

    typedef struct packed {
        logic [6:0] trim;
        logic [2:0] per_sel;
        logic       test_bit;
        logic       clkout_en1;
        logic       hour_mode;
        logic [1:0] alarm_en;
        logic       thr_sel;
        logic       clkout_en2;
        logic [2:0] scratch;
        logic [2:0] irq_flag;
    } cfg_t;

    function automatic health_e classify(input logic halt, input logic drop);
        if (halt)      return ST_HALTED;
        else if (drop) return ST_SUPPLY;
        else           return ST_CLEAN;
    endfunction

    function automatic logic [7:0] read_reg(input cfg_t c, input logic halt,
                                            input logic drop, input logic [1:0] a);
        case (a)
            A_TRIM:  return {1'b0, c.trim};
            A_CTLA:  return {c.per_sel, c.test_bit, c.clkout_en1, c.hour_mode, c.alarm_en};
            A_CTLB:  return {halt, drop, c.thr_sel, c.clkout_en2, 4'b0000};
            default: return {2'b00, c.scratch, c.irq_flag};
        endcase
    endfunction

    function automatic cfg_t write_reg(input cfg_t c, input logic [1:0] a,
                                       input logic [7:0] d);
        cfg_t r;
        r = c;
        case (a)
            A_TRIM: r.trim = d[6:0];
            A_CTLA: begin
                r.per_sel    = d[7:5];
                r.test_bit   = d[4];
                r.clkout_en1 = d[3];
                r.hour_mode  = d[2];
                r.alarm_en   = d[1:0];
            end
            A_CTLB: begin
                r.thr_sel    = d[5];
                r.clkout_en2 = d[4];
            end
            default: begin
                r.scratch  = d[5:3];
                r.irq_flag = d[2:0];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/halt_sense.sv
module halt_sense #(
    parameter int HALT_TIMEOUT = 128,
    parameter int INIT_EDGES   = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    input  logic ce,
    output logic halt_cond,
    output logic init_done
);
    localparam int HMAX = HALT_TIMEOUT + 1;
    localparam int HW   = $clog2(HMAX + 1);
    localparam int IW   = $clog2(INIT_EDGES + 1);

    logic [2:0]    osc_sync;
    logic          osc_rise;
    logic [HW-1:0] gap_cnt;
    logic [IW-1:0] init_cnt;

    assign osc_rise  = osc_sync[1] & ~osc_sync[2];
    assign init_done = (init_cnt == IW'(INIT_EDGES));
    assign halt_cond = ~ce & init_done & (gap_cnt > HW'(HALT_TIMEOUT));

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_sync <= '0;
            gap_cnt  <= '0;
            init_cnt <= '0;
        end else begin
            osc_sync <= {osc_sync[1:0], osc_in};
            if (osc_rise)
                gap_cnt <= '0;
            else if (gap_cnt != HW'(HMAX))
                gap_cnt <= gap_cnt + 1'b1;
            if (osc_rise && !init_done)
                init_cnt <= init_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drop_filter.sv
module drop_filter #(
    parameter int DROP_HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_low,
    input  logic init_done,
    output logic drop_cond
);
    localparam int DW = $clog2(DROP_HOLD + 1);

    logic [1:0]    cmp_sync;
    logic [DW-1:0] run_cnt;

    assign drop_cond = init_done & (run_cnt == DW'(DROP_HOLD));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_sync <= '0;
            run_cnt  <= '0;
        end else begin
            cmp_sync <= {cmp_sync[0], cmp_low};
            if (!cmp_sync[1])
                run_cnt <= '0;
            else if (run_cnt != DW'(DROP_HOLD))
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import rtc_flags_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    input  logic       halt_cond,
    input  logic       drop_cond,
    output cfg_t       cfg,
    output logic       halt_flag,
    output logic       drop_flag
);
    cfg_t cfg_n;
    logic halt_n;
    logic drop_n;

    always_comb begin
        cfg_n  = cfg;
        halt_n = halt_flag;
        drop_n = drop_flag;
        if (wr_en) begin
            cfg_n = write_reg(cfg, addr, wr_data);
            if (addr == A_CTLB) begin
                if (!wr_data[7]) halt_n = 1'b0;
                if (!wr_data[6]) drop_n = 1'b0;
            end
        end
        if (drop_cond) drop_n = 1'b1;
        if (halt_cond) begin
            halt_n = 1'b1;
            drop_n = 1'b0;
            cfg_n  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            halt_flag <= 1'b1;
            drop_flag <= 1'b0;
        end else begin
            cfg       <= cfg_n;
            halt_flag <= halt_n;
            drop_flag <= drop_n;
        end
    end
endmodule

// File: rtl/rtc_health_flags.sv
module rtc_health_flags
    import rtc_flags_pkg::*;
#(
    parameter int HALT_TIMEOUT = 128,
    parameter int DROP_HOLD    = 16,
    parameter int INIT_EDGES   = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_in,
    input  logic       cmp_low,
    input  logic       ce,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       thr_sel,
    output logic       halt_flag,
    output logic       drop_flag,
    output logic [1:0] status,
    output logic       init_done
);
    logic halt_cond;
    logic drop_cond;
    cfg_t cfg;

    halt_sense #(.HALT_TIMEOUT(HALT_TIMEOUT), .INIT_EDGES(INIT_EDGES)) u_halt (
        .clk(clk), .rst(rst), .osc_in(osc_in), .ce(ce),
        .halt_cond(halt_cond), .init_done(init_done)
    );

    drop_filter #(.DROP_HOLD(DROP_HOLD)) u_drop (
        .clk(clk), .rst(rst), .cmp_low(cmp_low), .init_done(init_done),
        .drop_cond(drop_cond)
    );

    flag_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .halt_cond(halt_cond), .drop_cond(drop_cond), .cfg(cfg),
        .halt_flag(halt_flag), .drop_flag(drop_flag)
    );

    assign rd_data = read_reg(cfg, halt_flag, drop_flag, addr);
    assign status  = classify(halt_flag, drop_flag);
    assign thr_sel = cfg.thr_sel;
endmodule

// File: rtl/rtc_health_flags_chk.sv
module rtc_health_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wr_data,
    input logic       halt_cond,
    input logic       drop_cond,
    input logic       init_done,
    input logic       halt_flag,
    input logic       drop_flag,
    input logic       thr_sel
);
    logic clr_halt_wr;
    logic clr_drop_wr;
    assign clr_halt_wr = wr_en && addr == 2'd2 && !wr_data[7];
    assign clr_drop_wr = wr_en && addr == 2'd2 && !wr_data[6];

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (halt_flag && !clr_halt_wr) |=> halt_flag);                          // R5
    AST_HALT_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!halt_flag && !halt_cond) |=> !halt_flag);                          // R5
    AST_CE_HIGH_NO_HALT: assert property (@(posedge clk) disable iff (rst)
        (ce && !halt_flag) |=> !halt_flag);                                  // R3
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (drop_flag && !clr_drop_wr && !halt_cond) |=> drop_flag);            // R6
    AST_HALT_WIPES: assert property (@(posedge clk) disable iff (rst)
        halt_cond |=> (!drop_flag && !thr_sel && halt_flag));                // R7
    AST_NO_DROP_IN_INIT: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !drop_flag && !drop_cond) |=> !drop_flag);            // R10
endmodule

bind rtc_health_flags rtc_health_flags_chk u_chk (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .halt_cond(halt_cond), .drop_cond(drop_cond), .init_done(init_done),
    .halt_flag(halt_flag), .drop_flag(drop_flag), .thr_sel(thr_sel)
);

// File: tb/rtc_health_flags_bench.sv
module rtc_health_flags_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO   = 20;
    localparam int HOLD = 5;
    localparam int INIT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_in = 1'b0;
    logic cmp_low = 1'b0;
    logic ce = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic thr_sel, halt_flag, drop_flag, init_done;
    logic [1:0] status;
    logic osc_run = 1'b1;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_health_flags #(.HALT_TIMEOUT(TO), .DROP_HOLD(HOLD), .INIT_EDGES(INIT)) u_rtc_health_flags (
        .clk(clk), .rst(rst), .osc_in(osc_in), .cmp_low(cmp_low), .ce(ce),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .thr_sel(thr_sel), .halt_flag(halt_flag), .drop_flag(drop_flag),
        .status(status), .init_done(init_done)
    );

    // behavioural reference model
    bit m_ready = 0;
    bit m_halt, m_drop;
    bit osc_hist[$];
    bit cmp_hist[$];
    int m_gap, m_edges, m_run;
    logic [7:0] m_reg [4];
    logic [7:0] wmask [4] = '{8'h7F, 8'hFF, 8'h30, 8'h3F};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_halt = 1; m_drop = 0; m_gap = 0; m_edges = 0; m_run = 0;
            osc_hist = '{0, 0, 0}; cmp_hist = '{0, 0};
            for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        end else begin
            bit rise, hc, dc;
            rise = osc_hist[1] && !osc_hist[2];
            hc = !ce && (m_edges == INIT) && (m_gap > TO);
            dc = (m_edges == INIT) && (m_run == HOLD);
            if (rise) m_gap = 0; else if (m_gap < TO + 1) m_gap++;
            if (rise && m_edges < INIT) m_edges++;
            if (cmp_hist[1]) begin if (m_run < HOLD) m_run++; end else m_run = 0;
            osc_hist.push_front(osc_in); void'(osc_hist.pop_back());
            cmp_hist.push_front(cmp_low); void'(cmp_hist.pop_back());
            if (wr_en) begin
                m_reg[addr] = wr_data & wmask[addr];
                if (addr == 2'd2 && !wr_data[7]) m_halt = 0;
                if (addr == 2'd2 && !wr_data[6]) m_drop = 0;
            end
            if (dc) m_drop = 1;
            if (hc) begin
                m_halt = 1; m_drop = 0;
                for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
            end
        end
        m_ready = 1;
        #(CLK_PERIOD/4);
        check("R2 halt_flag", {7'd0, halt_flag}, {7'd0, m_halt});
        check("R4 drop_flag", {7'd0, drop_flag}, {7'd0, m_drop});
        check("R11 rd_data", rd_data,
              (addr == 2'd2) ? (m_reg[2] | {m_halt, m_drop, 6'd0}) : m_reg[addr]);
        check("R8 status", {6'd0, status}, m_halt ? 8'd2 : (m_drop ? 8'd1 : 8'd0));
        check("R9 thr_sel", {7'd0, thr_sel}, {7'd0, m_reg[2][5]});
        check("R10 init_done", {7'd0, init_done}, {7'd0, m_edges == INIT});
    end

    // slow clock stimulus: period of 8 reference cycles while running
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (osc_run) begin
                ph++;
                if (ph == 4) begin osc_in = ~osc_in; ph = 0; end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst = 0;
        rd(2'd2, v); check("R1 reg2 after reset", v, 8'h80);
        check("R1 status after reset", {6'd0, status}, 8'h02);
        check("R1 init_done after reset", {7'd0, init_done}, 8'h00);
        idle(60);
        wr(2'd2, 8'h00); check("R5 halt cleared by 0", {7'd0, halt_flag}, 8'h00);
        wr(2'd2, 8'hC0); rd(2'd2, v); check("R5 writing 1s sets nothing", v, 8'h00);
        wr(2'd0, 8'hD5); wr(2'd1, 8'hFF); wr(2'd2, 8'h30); wr(2'd3, 8'hFF);
        rd(2'd0, v); check("R11 reg0", v, 8'h55);
        rd(2'd3, v); check("R11 reg3", v, 8'h3F);
        check("R9 thr_sel high", {7'd0, thr_sel}, 8'h01);
        // short comparator pulse then a long one
        cmp_low = 1; idle(3); cmp_low = 0; idle(10);
        check("R4 short pulse ignored", {7'd0, drop_flag}, 8'h00);
        cmp_low = 1; idle(12);
        check("R4 drop set", {7'd0, drop_flag}, 8'h01);
        check("R8 supply status", {6'd0, status}, 8'h01);
        wr(2'd2, 8'h30); idle(1);
        check("R6 drop clear loses to live event", {7'd0, drop_flag}, 8'h01);
        cmp_low = 0; idle(6);
        wr(2'd2, 8'h30);
        check("R5 drop cleared", {7'd0, drop_flag}, 8'h00);
        cmp_low = 1; idle(12); cmp_low = 0; idle(4);
        // stop slow clock with ce high
        ce = 1; osc_run = 0; idle(100);
        check("R3 no halt while ce high", {7'd0, halt_flag}, 8'h00);
        osc_run = 1; idle(30); ce = 0; idle(20);
        check("R3 no halt after restart", {7'd0, halt_flag}, 8'h00);
        // stop slow clock with ce low
        osc_run = 0; idle(40);
        check("R2 halt detected", {7'd0, halt_flag}, 8'h01);
        check("R8 halt precedence", {6'd0, status}, 8'h02);
        rd(2'd0, v); check("R7 reg0 wiped", v, 8'h00);
        rd(2'd1, v); check("R7 reg1 wiped", v, 8'h00);
        rd(2'd2, v); check("R7 reg2 wiped", v, 8'h80);
        rd(2'd3, v); check("R7 reg3 wiped", v, 8'h00);
        wr(2'd1, 8'hAA); rd(2'd1, v); check("R7 write lost during halt", v, 8'h00);
        wr(2'd2, 8'h00); idle(1);
        check("R6 halt clear loses to live event", {7'd0, halt_flag}, 8'h01);
        ce = 1; osc_run = 1; idle(30);
        check("R3 captured halt kept", {7'd0, halt_flag}, 8'h01);
        ce = 0; idle(5);
        wr(2'd2, 8'h00);
        check("R5 halt cleared after restart", {7'd0, halt_flag}, 8'h00);
        // reset with slow clock stopped and comparator high
        osc_run = 0; rst = 1; idle(3); rst = 0;
        cmp_low = 1; idle(5);
        wr(2'd2, 8'h00); idle(60);
        check("R10 no halt before init", {7'd0, halt_flag}, 8'h00);
        check("R10 no drop before init", {7'd0, drop_flag}, 8'h00);
        osc_run = 1; idle(60);
        check("R10 drop set after init", {7'd0, drop_flag}, 8'h01);
        cmp_low = 0; idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule